// File: doc/BRIEF.md
# Quad SPI Command Engine

A register-driven serial flash master that runs one SPI word per accepted write to its command register. Software sets a clock divider with an enable bit and a device-control byte for each chip select, then loads up to 128 bits of transmit data into four data registers. A command write picks the chip select, the word length (1 to 128 bits), single-line read or write, and 3-pin operation, or it ends the current frame. The engine drives SCLK, the chip-select lines and the data line, and it reports word-complete and busy in a status register.

A frame is a run of words to one device. The chip select stays asserted between the words of a frame. It is released when the programmed word count is reached or when an end-frame command arrives. Received bits land in the data registers when the word completes, so software can read them back.

Register word addresses (`reg_addr_i`): 0 clock control, 1 device control, 2 command, 3 status, 4 to 7 data words 0 to 3. Reads are combinational from `reg_addr_i`. Writes take effect on the clock edge where `reg_we_i` is high.

Top module: `qspi_cmd_engine`

## Requirements
- R1: After reset every `cs_o` line is at 1 (all chip-select polarities low, so deasserted), `sclk_o` is 0, `sd0_oe_o` is 1, and the status register reads 0.
- R2: Clock control holds the divider in bits 15:0 and the enable in bit 31. With the enable set, one SCLK period lasts 2*(divider+1) `clk_i` cycles. Clearing the enable during a word freezes the word (busy stays 1) and holds SCLK at its idle level until the enable is set again, after which the word completes.
- R3: A write word of L bits shifts the low L bits of {data3,data2,data1,data0} out on `sd0_o`, most significant bit first. A 128-bit word therefore starts with bit 31 of data3.
- R4: A read word samples `sd1_i`, or `sd0_i` when 3-pin mode is set, and on completion places the word in the low bits of the data registers (data0 bits 31:0 first). During a 3-pin read `sd0_oe_o` is 0. During a write it is 1.
- R5: Device-control byte n (bits 8n+7:8n) configures chip select n. Bit 0 is the SCLK idle level. Bit 2 at 0 samples on the leading SCLK edge of each bit, and bit 2 at 1 samples on the trailing edge. Data changes on the opposite edge.
- R6: Command bits 29:28 select the chip select. The selected line is driven to the level of its device-control bit 1 while the frame is open. Every other line sits at the inverse of its own bit 1.
- R7: Command bits 11:0 give the frame length in words. The chip select stays asserted between words and is released after the word that reaches the count. A length of 0 or 1 releases it after one word.
- R8: A command whose bits 18:16 equal 4 starts no transfer. It releases the chip select at once and restarts the frame count.
- R9: Status bit 1 is word-complete and bit 0 is busy. Busy is 1 while a word shifts. Word-complete is set when the word ends and cleared by the next accepted command.
- R10: Command bits 25:19 hold the word length minus one, bit 18 selects 3-pin mode, and bits 17:16 select read (1) or write (2). Any command written while busy is ignored. So is any command with bits 17:16 equal to 0 or 3 that is not the end-frame code; such a command changes no state and clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | NUM_CS | Chip-select lines, polarity per device |
| sd0_o | output | 1 | Data line 0 output |
| sd0_oe_o | output | 1 | Data line 0 output enable |
| sd0_i | input | 1 | Data line 0 input (3-pin reads) |
| sd1_i | input | 1 | Data line 1 input (4-pin reads) |

## Verification
The assertions assume that register writes are single-cycle strobes and that the device-control byte of the open chip select is not rewritten in the middle of a word. They also assume that the divider is only changed while no word is shifting. The stimulus changes configuration only after word-complete is seen. The one overlapping command is the deliberate busy-collision case, and the enable toggle is the only mid-word register write. The bench's serial monitor decides sample edges from the mode it programmed. It ignores SCLK movement while every chip select is idle, and it is switched off around the clock-stall case, where forcing SCLK idle creates an edge that is not a bit.

// File: rtl/qspi_cmd_pkg.sv
package qspi_cmd_pkg;
  typedef enum logic [2:0] {
    A_CLK  = 3'd0,
    A_DEV  = 3'd1,
    A_CMD  = 3'd2,
    A_STAT = 3'd3,
    A_D0   = 3'd4,
    A_D1   = 3'd5,
    A_D2   = 3'd6,
    A_D3   = 3'd7
  } reg_addr_e;

  localparam int CLK_EN_BIT = 31;
  localparam int CS_LSB     = 28;
  localparam int LEN_LSB    = 19;
  localparam int PIN3_BIT   = 18;
  localparam int FN_LSB     = 16;

  localparam logic [1:0] FN_READ  = 2'b01;
  localparam logic [1:0] FN_WRITE = 2'b10;
  localparam logic [2:0] OP_END   = 3'b100;
endpackage

// File: rtl/qspi_clk_div.sv
module qspi_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // one tick per SCLK half period
  assign tick_o = run_i && en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int W     = 128,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic [W-1:0]     txd_i,
  input  logic             sdi_i,
  output logic             busy_o,
  output logic             half_o,
  output logic             done_o,
  output logic             sdo_o,
  output logic [W-1:0]     rxd_o
);
  logic             busy_q, half_q;
  logic [LEN_W-1:0] bitcnt_q;
  logic [W-1:0]     sh_q, rx_q;
  logic [LEN_W-1:0] shamt;

  assign shamt  = LEN_W'(W-1) - len_m1_i;
  assign busy_o = busy_q;
  assign half_o = half_q;
  assign sdo_o  = sh_q[W-1];
  assign rxd_o  = rx_q;
  assign done_o = busy_q && tick_i && half_q && (bitcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      half_q   <= 1'b0;
      bitcnt_q <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      half_q   <= 1'b0;
      bitcnt_q <= len_m1_i;
      sh_q     <= txd_i << shamt;  // word MSB to the top
      rx_q     <= '0;
    end else if (busy_q && tick_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
        rx_q   <= {rx_q[W-2:0], sdi_i};
      end else begin
        half_q <= 1'b0;
        if (bitcnt_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          bitcnt_q <= bitcnt_q - 1'b1;
          sh_q     <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R10
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i && !start_i) |=> ($stable(bitcnt_q) && $stable(half_q))); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R9
endmodule

// File: rtl/qspi_frame_ctl.sv
module qspi_frame_ctl #(
  parameter int CS_W   = 2,
  parameter int FLEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              done_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [FLEN_W-1:0] flen_i,
  output logic              cs_act_o,
  output logic [CS_W-1:0]   cs_sel_o
);
  logic              cs_act_q;
  logic [CS_W-1:0]   cs_sel_q;
  logic [FLEN_W-1:0] flen_q, wcnt_q;
  logic [FLEN_W:0]   wcnt_inc;

  assign wcnt_inc = {1'b0, wcnt_q} + 1'b1;
  assign cs_act_o = cs_act_q;
  assign cs_sel_o = cs_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_act_q <= 1'b0;
      cs_sel_q <= '0;
      flen_q   <= '0;
      wcnt_q   <= '0;
    end else if (end_i) begin
      cs_act_q <= 1'b0;
      wcnt_q   <= '0;
    end else if (start_i) begin
      cs_act_q <= 1'b1;
      cs_sel_q <= cs_i;
      flen_q   <= flen_i;
    end else if (done_i) begin
      if (wcnt_inc >= {1'b0, flen_q}) begin
        cs_act_q <= 1'b0;
        wcnt_q   <= '0;
      end else begin
        wcnt_q <= wcnt_inc[FLEN_W-1:0];
      end
    end
  end

  AST_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> !cs_act_q); // R8
  AST_START_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !end_i) |=> (cs_act_q && cs_sel_q == $past(cs_i))); // R6
endmodule

// File: rtl/qspi_cmd_engine.sv
module qspi_cmd_engine
  import qspi_cmd_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int DIV_W    = 16,
  parameter int FLEN_W   = 12,
  parameter int WORD_MAX = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic              sd0_o,
  output logic              sd0_oe_o,
  input  logic              sd0_i,
  input  logic              sd1_i
);
  localparam int LEN_W = $clog2(WORD_MAX);
  localparam int NREG  = WORD_MAX / 32;
  localparam int CS_W  = $clog2(NUM_CS);

  logic             clk_en_q;
  logic [DIV_W-1:0] div_q;
  logic [8*NUM_CS-1:0] dc_q;
  logic [31:0]      cmd_q;
  logic             wc_q, rd_q, pin3_q;
  logic [31:0]      data_q [NREG];
  logic [WORD_MAX-1:0] txd, rxd;

  logic busy, half, done, tick, sdi;
  logic cs_act;
  logic [CS_W-1:0] cs_sel;

  // command decode
  logic [1:0] fn;
  logic       is_rd, is_wr, is_end, cmd_we, cmd_acc, start;
  assign fn      = reg_wdata_i[FN_LSB +: 2];
  assign is_rd   = (fn == FN_READ);
  assign is_wr   = (fn == FN_WRITE);
  assign is_end  = (reg_wdata_i[FN_LSB +: 3] == OP_END);
  assign cmd_we  = reg_we_i && (reg_addr_i == A_CMD);
  assign cmd_acc = cmd_we && !busy && (is_rd || is_wr || is_end);
  assign start   = cmd_acc && (is_rd || is_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_q <= 1'b0;
      div_q    <= '0;
      dc_q     <= '0;
      cmd_q    <= '0;
      wc_q     <= 1'b0;
      rd_q     <= 1'b0;
      pin3_q   <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == A_CLK) begin
        clk_en_q <= reg_wdata_i[CLK_EN_BIT];
        div_q    <= reg_wdata_i[DIV_W-1:0];
      end
      if (reg_we_i && reg_addr_i == A_DEV) dc_q <= reg_wdata_i[8*NUM_CS-1:0];
      if (cmd_acc) begin
        cmd_q <= reg_wdata_i;
        wc_q  <= 1'b0;
      end else if (done) begin
        wc_q <= 1'b1;
      end
      if (start) begin
        rd_q   <= is_rd;
        pin3_q <= reg_wdata_i[PIN3_BIT];
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_data
    assign txd[i*32 +: 32] = data_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    data_q[i] <= '0;
      else if (done && rd_q)                          data_q[i] <= rxd[i*32 +: 32];
      else if (reg_we_i && reg_addr_i == 3'(4 + i))   data_q[i] <= reg_wdata_i;
    end
  end

  qspi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy), .en_i (clk_en_q),
    .div_i (div_q), .tick_o (tick)
  );

  assign sdi = pin3_q ? sd0_i : sd1_i;

  qspi_shifter #(.W(WORD_MAX), .LEN_W(LEN_W)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start), .tick_i (tick),
    .len_m1_i (reg_wdata_i[LEN_LSB +: LEN_W]), .txd_i (txd), .sdi_i (sdi),
    .busy_o (busy), .half_o (half), .done_o (done), .sdo_o (sd0_o), .rxd_o (rxd)
  );

  qspi_frame_ctl #(.CS_W(CS_W), .FLEN_W(FLEN_W)) u_frame (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start), .end_i (cmd_acc && is_end),
    .done_i (done), .cs_i (reg_wdata_i[CS_LSB +: CS_W]),
    .flen_i (reg_wdata_i[FLEN_W-1:0]), .cs_act_o (cs_act), .cs_sel_o (cs_sel)
  );

  // per-device mode from the open chip select's byte
  logic [7:0] dev;
  logic       cpol, cpha;
  assign dev  = dc_q[cs_sel*8 +: 8];
  assign cpol = dev[0];
  assign cpha = dev[2];

  assign sclk_o   = cpol ^ (clk_en_q && busy && (cpha ? !half : half));
  assign sd0_oe_o = !(busy && rd_q && pin3_q);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_o[i] = (cs_act && cs_sel == CS_W'(i)) ? dc_q[8*i+1] : !dc_q[8*i+1];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CLK: begin
        reg_rdata_o[CLK_EN_BIT]  = clk_en_q;
        reg_rdata_o[DIV_W-1:0]   = div_q;
      end
      A_DEV:  reg_rdata_o[8*NUM_CS-1:0] = dc_q;
      A_CMD:  reg_rdata_o = cmd_q;
      A_STAT: reg_rdata_o[1:0] = {wc_q, busy};
      default: reg_rdata_o = data_q[reg_addr_i[1:0]];
    endcase
  end

  AST_WC_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wc_q |-> !busy); // R9
  AST_CMD_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we) |=> $stable(cmd_q)); // R10
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && is_wr) |=> sd0_oe_o); // R4
endmodule

// File: tb/qspi_cmd_engine_tb.sv
`timescale 1ns/1ps
module qspi_cmd_engine_tb;
  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        sclk, sd0, sd0_oe;
  logic [3:0]  cs;
  logic        sd1_r = 0;

  always #4 clk = ~clk;

  qspi_cmd_engine u_dut (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .sclk_o (sclk), .cs_o (cs),
    .sd0_o (sd0), .sd0_oe_o (sd0_oe), .sd0_i (~sd1_r), .sd1_i (sd1_r)
  );

  int checks = 0, errors = 0;

  typedef struct { int len; bit rd; logic [127:0] data; } item_t;
  item_t q[$];

  logic [31:0]  dc_val = 0;
  logic [3:0]   cs_idle = 4'hF;
  bit           cur_cpol = 0, cur_cpha = 0, mon_en = 1;
  int           mcnt = 0;
  logic [127:0] cap = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] lmask(input int len);
    return (len >= 128) ? {128{1'b1}} : ((128'd1 << len) - 1);
  endfunction

  // monitor: acts as the serial device and scoreboards write words
  always @(sclk) begin
    if (mon_en && cs !== cs_idle && q.size() > 0) begin
      if ((!cur_cpha && sclk != cur_cpol) || (cur_cpha && sclk == cur_cpol)) begin
        if (!q[0].rd) cap = {cap[126:0], sd0};
        mcnt++;
        if (mcnt == q[0].len) begin
          if (!q[0].rd)
            chk((cap & lmask(q[0].len)) == (q[0].data & lmask(q[0].len)), "R3 mosi word",
                cap & lmask(q[0].len), q[0].data & lmask(q[0].len));
          void'(q.pop_front());
          mcnt = 0;
          cap = 0;
        end
        if (q.size() > 0 && q[0].rd) sd1_r = q[0].data[q[0].len-1-mcnt];
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_dc(input logic [31:0] v);
    dc_val = v;
    for (int i = 0; i < 4; i++) cs_idle[i] = ~v[8*i+1];
    reg_wr(3'd1, v);
  endtask

  function automatic logic [31:0] mk_cmd(input int csn, input int len, input int fn,
                                         input bit pin3, input int flen);
    return (32'(csn) << 28) | (32'(len - 1) << 19) | (32'(pin3) << 18) |
           (32'(fn) << 16) | 32'(flen);
  endfunction

  task automatic start_word(input int csn, input int len, input bit rd, input bit pin3,
                            input int flen, input logic [127:0] d, input bit push);
    item_t it;
    if (!rd) for (int i = 0; i < 4; i++) reg_wr(3'(4 + i), d[i*32 +: 32]);
    cur_cpol = dc_val[8*csn];
    cur_cpha = dc_val[8*csn+2];
    if (push) begin
      it.len = len; it.rd = rd; it.data = d;
      if (q.size() == 0 && rd) sd1_r = d[len-1];
      q.push_back(it);
    end
    reg_wr(3'd2, mk_cmd(csn, len, rd ? 1 : 2, pin3, flen));
  endtask

  task automatic wait_wc(input string req);
    logic [31:0] v;
    bit seen = 0;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(3'd3, v);
      if (v[1]) begin seen = 1; break; end
    end
    chk(seen, req, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_rd(3'd3, v);
    chk(v == 0, "R1 status", v, 0);
    chk(cs == 4'hF, "R1 cs", cs, 4'hF);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(sd0_oe == 1, "R1 oe", sd0_oe, 1);

    reg_wr(3'd0, 32'h8000_0001);
    set_dc(32'h0);
    // R3 8-bit write, R9 status, R7 single-word frame
    start_word(0, 8, 0, 0, 1, 128'hA5, 1);
    wait_wc("R9 wc");
    reg_rd(3'd3, v);
    chk(v == 32'h2, "R9 status done", v, 2);
    chk(cs == 4'hF, "R7 release after one word", cs, 4'hF);

    // R2 period with divider 2
    reg_wr(3'd0, 32'h8000_0002);
    start_word(0, 16, 0, 0, 0, 128'h1234, 1);
    @(posedge sclk); t0 = $realtime;
    @(posedge sclk); t1 = $realtime;
    chk((t1 - t0) == 48.0, "R2 period div2", 128'(int'(t1 - t0)), 48);
    wait_wc("R2 wc");
    reg_wr(3'd0, 32'h8000_0000);
    start_word(0, 8, 0, 0, 1, 128'h5A, 1);
    @(posedge sclk); t0 = $realtime;
    @(posedge sclk); t1 = $realtime;
    chk((t1 - t0) == 16.0, "R2 period div0", 128'(int'(t1 - t0)), 16);
    wait_wc("R2 wc0");

    // R3 128-bit word
    start_word(0, 128, 0, 0, 1, 128'h89ABCDEF_01234567_FEDCBA98_76543210, 1);
    wait_wc("R3 wc128");

    // R4 4-pin read and 3-pin read
    start_word(0, 8, 1, 0, 1, 128'h3C, 1);
    wait_wc("R4 wc rd");
    reg_rd(3'd4, v);
    chk(v == 32'h3C, "R4 read data0", v, 32'h3C);
    reg_wr(3'd0, 32'h8000_0003);
    start_word(0, 8, 1, 1, 1, 128'h96, 1);
    repeat (4) @(negedge clk);
    chk(sd0_oe == 0, "R4 3-pin oe", sd0_oe, 0);
    wait_wc("R4 wc 3pin");
    reg_rd(3'd4, v);
    chk(v == 32'h69, "R4 3-pin data0", v, 32'h69);
    reg_wr(3'd0, 32'h8000_0001);

    // R5/R6 cs2, idle high clock, trailing-edge sample, active-high select
    set_dc(32'h0007_0000);
    chk(cs == 4'b1011, "R6 idle levels", cs, 4'b1011);
    start_word(2, 12, 0, 0, 1, 128'hC3A, 1);
    repeat (2) @(negedge clk);
    chk(cs == 4'b1111, "R6 cs2 asserted high", cs, 4'b1111);
    wait_wc("R5 wc");
    chk(sclk == 1, "R5 idle level cpol1", sclk, 1);
    start_word(2, 8, 1, 0, 1, 128'hC3, 1);
    wait_wc("R5 wc rd");
    reg_rd(3'd4, v);
    chk(v == 32'hC3, "R5 read mode3", v, 32'hC3);
    set_dc(32'h0);

    // R7 three-word frame on cs1
    start_word(1, 8, 0, 0, 3, 128'h11, 1);
    wait_wc("R7 w1");
    chk(cs == 4'b1101, "R7 held after w1", cs, 4'b1101);
    start_word(1, 8, 0, 0, 3, 128'h22, 1);
    wait_wc("R7 w2");
    chk(cs == 4'b1101, "R7 held after w2", cs, 4'b1101);
    start_word(1, 8, 0, 0, 3, 128'h33, 1);
    wait_wc("R7 w3");
    chk(cs == 4'b1111, "R7 released after w3", cs, 4'b1111);

    // R8 end-frame command
    start_word(0, 8, 0, 0, 5, 128'h44, 1);
    wait_wc("R8 w1");
    chk(cs == 4'b1110, "R8 open frame", cs, 4'b1110);
    reg_wr(3'd2, 32'h0004_0000);
    chk(cs == 4'b1111, "R8 released", cs, 4'b1111);
    reg_rd(3'd3, v);
    chk(v == 0, "R9 wc cleared by command", v, 0);

    // R10 command while busy, and unused code
    reg_wr(3'd0, 32'h8000_0007);
    start_word(0, 16, 0, 0, 1, 128'hBEEF, 1);
    repeat (2) @(negedge clk);
    reg_wr(3'd2, mk_cmd(3, 8, 1, 0, 1));
    chk(cs == 4'b1110, "R10 busy cmd ignored cs", cs, 4'b1110);
    wait_wc("R10 wc");
    reg_rd(3'd2, v);
    chk(v == mk_cmd(0, 16, 2, 0, 1), "R10 cmd kept", v, mk_cmd(0, 16, 2, 0, 1));
    reg_wr(3'd2, mk_cmd(0, 8, 3, 0, 1));
    reg_rd(3'd3, v);
    chk(v == 32'h2, "R10 code3 ignored status", v, 2);
    chk(cs == 4'hF, "R10 code3 ignored cs", cs, 4'hF);

    // R2 stall with enable cleared
    mon_en = 0;
    reg_wr(3'd0, 32'h8000_0001);
    start_word(0, 16, 0, 0, 1, 128'hFFFF, 0);
    repeat (5) @(negedge clk);
    reg_wr(3'd0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    chk(sclk == 0, "R2 stalled sclk idle", sclk, 0);
    reg_rd(3'd3, v);
    chk(v == 32'h1, "R2 stalled busy", v, 1);
    reg_wr(3'd0, 32'h8000_0001);
    wait_wc("R2 resume");
    mon_en = 1;
    mcnt = 0;

    chk(q.size() == 0, "R3 all words seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule